// File: doc/BRIEF.md
# Modem Control and Status Unit

This block holds the modem-side registers of a 16550-style serial port. A byte-wide strobe port reads and writes two locations. One is a five-bit control register that drives the DTR, RTS, OUT1 and OUT2 outputs and a loopback flag. The other is a status register that reports the four incoming modem lines and records their changes. The four inputs are asynchronous. Each passes through a synchroniser before the change detector compares it with the previous sample.

The change detector keeps four sticky flags. CTS, DSR and DCD flag any change of level. The ring line is flagged only when it falls from 1 to 0. A status read returns the flags and clears them. While any flag is set and the enable input is high, the block raises a modem-status interrupt condition. With the loopback bit set, a status read returns the control bits remapped onto the line positions, and the loopback flag goes to the serial data path.

Top module: `modem_ctl_unit`

## Requirements
- R1: After reset the control register holds 0x08, so out2_o is 1 and dtr_o, rts_o, out1_o, loop_o and msi_o are 0. The line levels present at reset raise no change flag and no interrupt.
- R2: A write with sel=0 stores wdata[4:0] as the control register (bit 0 DTR, bit 1 RTS, bit 2 OUT1, bit 3 OUT2, bit 4 loop), and the outputs show the new value after that edge. A read with sel=0 returns {3'b000, control}.
- R3: A read with sel=1 outside loopback returns the synchronised line levels on bits 7..4 (bit 4 CTS, bit 5 DSR, bit 6 RI, bit 7 DCD) and the change flags on bits 3..0.
- R4: Bits 0, 1 and 3 of the status register (CTS, DSR and DCD change) are set when the line level differs from the previous sample. They stay set until a status read, so a line that toggles and returns still shows its flag.
- R5: Bit 2 of the status register is set when RI goes from 1 to 0, and never when it goes from 0 to 1.
- R6: A status read outside loopback clears all four change flags at the read edge. A change detected in that same cycle is kept.
- R7: msi_o is registered and equals msi_en AND (any change flag set). After a line input changes, msi_o rises on the third rising clock edge.
- R8: In loopback, a status read returns OUT2 on bit 7, OUT1 on bit 6, DTR on bit 5 and RTS on bit 4, with bits 3..0 zero. Such a read leaves the held change flags intact.
- R9: loop_o equals control bit 4.
- R10: A write with sel=1 changes neither the status register nor the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| sel | input | 1 | 0 selects the control register, 1 selects the status register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered, held between reads |
| msi_en | input | 1 | Modem-status interrupt enable |
| cts_i | input | 1 | Clear-to-send line (asynchronous) |
| dsr_i | input | 1 | Data-set-ready line (asynchronous) |
| ri_i | input | 1 | Ring line (asynchronous) |
| dcd_i | input | 1 | Carrier-detect line (asynchronous) |
| dtr_o | output | 1 | Data-terminal-ready output |
| rts_o | output | 1 | Request-to-send output |
| out1_o | output | 1 | General output 1 |
| out2_o | output | 1 | General output 2 |
| loop_o | output | 1 | Loopback flag for the data path |
| msi_o | output | 1 | Modem-status interrupt condition |

## Verification
A wrong previous-sample register or a wrong flag shows up in two places. msi_o goes wrong on the third edge after a line change, and the next status read returns the wrong low nibble. The bench therefore checks msi_o exactly at that edge, and once the cycle before it, for every pair of old and new line levels. A flag that is not cleared, or that is lost, shows at the following read. A wrong loopback mapping shows on the first status read after the control write.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int NLINES = 4;
  // line vector positions (status bits 4..7 in this order)
  localparam int L_CTS = 0;
  localparam int L_DSR = 1;
  localparam int L_RI  = 2;
  localparam int L_DCD = 3;
  // control register bit positions
  localparam int CTRL_W = 5;
  localparam int C_DTR  = 0;
  localparam int C_RTS  = 1;
  localparam int C_OUT1 = 2;
  localparam int C_OUT2 = 3;
  localparam int C_LOOP = 4;
  localparam logic [CTRL_W-1:0] CTRL_RST = 5'b01000;

  // control outputs seen as line inputs while in loopback
  function automatic logic [NLINES-1:0] loop_lines(input logic [CTRL_W-1:0] c);
    logic [NLINES-1:0] l;
    l[L_CTS] = c[C_RTS];
    l[L_DSR] = c[C_DTR];
    l[L_RI]  = c[C_OUT1];
    l[L_DCD] = c[C_OUT2];
    return l;
  endfunction
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/mdm_ctrl_reg.sv
module mdm_ctrl_reg
  import mdm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [CTRL_W-1:0] din,
  output logic [CTRL_W-1:0] ctrl
);
  always_ff @(posedge clk) begin
    if (rst)     ctrl <= CTRL_RST;
    else if (wr) ctrl <= din;
  end
endmodule

// File: rtl/mdm_status.sv
module mdm_status
  import mdm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] lines,
  input  logic              clr,
  input  logic              irq_en,
  output logic [NLINES-1:0] cur,
  output logic [NLINES-1:0] delta,
  output logic              irq
);
  // hold off change detection until the synchroniser carries real levels
  localparam int PRIME = SYNC_STAGES + 1;
  localparam int CW    = $clog2(PRIME + 1);

  logic [CW-1:0]     prime_cnt;
  logic              priming;
  logic [NLINES-1:0] chg, set_bits, delta_d;

  assign priming = (prime_cnt != CW'(PRIME));
  assign chg     = lines ^ cur;

  always_comb begin
    set_bits         = chg;
    set_bits[L_RI]   = cur[L_RI] & ~lines[L_RI];   // trailing edge only
    delta_d          = priming ? '0 : ((clr ? '0 : delta) | set_bits);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prime_cnt <= '0;
      cur       <= '0;
      delta     <= '0;
      irq       <= 1'b0;
    end else begin
      if (priming) prime_cnt <= prime_cnt + 1'b1;
      cur   <= lines;
      delta <= delta_d;
      irq   <= irq_en & (|delta_d);
    end
  end
endmodule

// File: rtl/modem_ctl_unit.sv
module modem_ctl_unit
  import mdm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic       sel,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       msi_en,
  input  logic       cts_i,
  input  logic       dsr_i,
  input  logic       ri_i,
  input  logic       dcd_i,
  output logic       dtr_o,
  output logic       rts_o,
  output logic       out1_o,
  output logic       out2_o,
  output logic       loop_o,
  output logic       msi_o
);
  logic [NLINES-1:0] line_raw, line_sync, st_lines, st_delta;
  logic [CTRL_W-1:0] ctrl;
  logic              st_clear;

  always_comb begin
    line_raw        = '0;
    line_raw[L_CTS] = cts_i;
    line_raw[L_DSR] = dsr_i;
    line_raw[L_RI]  = ri_i;
    line_raw[L_DCD] = dcd_i;
  end

  mdm_sync #(.WIDTH(NLINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(line_raw), .q(line_sync)
  );

  mdm_ctrl_reg u_ctrl (
    .clk(clk), .rst(rst), .wr(wr_en & ~sel), .din(wdata[CTRL_W-1:0]), .ctrl(ctrl)
  );

  assign st_clear = rd_en & sel & ~ctrl[C_LOOP];

  mdm_status #(.SYNC_STAGES(SYNC_STAGES)) u_stat (
    .clk(clk), .rst(rst), .lines(line_sync), .clr(st_clear), .irq_en(msi_en),
    .cur(st_lines), .delta(st_delta), .irq(msi_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      if (!sel)              rdata <= {{(8-CTRL_W){1'b0}}, ctrl};
      else if (ctrl[C_LOOP]) rdata <= {loop_lines(ctrl), 4'b0000};
      else                   rdata <= {st_lines, st_delta};
    end
  end

  assign dtr_o  = ctrl[C_DTR];
  assign rts_o  = ctrl[C_RTS];
  assign out1_o = ctrl[C_OUT1];
  assign out2_o = ctrl[C_OUT2];
  assign loop_o = ctrl[C_LOOP];
endmodule

// File: rtl/modem_ctl_chk.sv
module modem_ctl_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic       rd_en,
  input logic       sel,
  input logic [7:0] wdata,
  input logic       msi_en,
  input logic       dtr_o,
  input logic       rts_o,
  input logic       out1_o,
  input logic       out2_o,
  input logic       loop_o,
  input logic       msi_o,
  input logic [3:0] line_sync,
  input logic [3:0] st_lines,
  input logic [3:0] st_delta
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (out2_o && !dtr_o && !rts_o && !out1_o && !loop_o && !msi_o));

  // R2
  ctrl_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !sel) |=> ({loop_o, out2_o, out1_o, rts_o, dtr_o} == $past(wdata[4:0])));

  // R4
  delta_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (st_delta[0] && !(rd_en && sel && !loop_o)) |=> st_delta[0]);

  // R5
  ring_trailing_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(st_delta[2]) |-> ($past(st_lines[2]) && !st_lines[2]));

  // R6
  read_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel && !loop_o && (line_sync == st_lines)) |=> (st_delta == 4'b0000));

  // R7
  msi_enable_chk: assert property (@(posedge clk) disable iff (rst)
    msi_o |-> $past(msi_en));
endmodule

bind modem_ctl_unit modem_ctl_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .sel(sel), .wdata(wdata),
  .msi_en(msi_en), .dtr_o(dtr_o), .rts_o(rts_o), .out1_o(out1_o), .out2_o(out2_o),
  .loop_o(loop_o), .msi_o(msi_o), .line_sync(line_sync), .st_lines(st_lines),
  .st_delta(st_delta)
);

// File: tb/modem_ctl_unit_test.sv
module modem_ctl_unit_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0, sel = 1'b0, msi_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [3:0] ln = 4'b1101;   // {dcd, ri, dsr, cts}
  logic       dtr_o, rts_o, out1_o, out2_o, loop_o, msi_o;
  int         total = 0, bad = 0;
  logic [7:0] rv;

  always #5 clk = ~clk;

  modem_ctl_unit uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .sel(sel), .wdata(wdata),
    .rdata(rdata), .msi_en(msi_en), .cts_i(ln[0]), .dsr_i(ln[1]), .ri_i(ln[2]),
    .dcd_i(ln[3]), .dtr_o(dtr_o), .rts_o(rts_o), .out1_o(out1_o), .out2_o(out2_o),
    .loop_o(loop_o), .msi_o(msi_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_wr(input logic s, input logic [7:0] v);
    sel = s; wdata = v; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic s, output logic [7:0] v);
    sel = s; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [3:0] exp_d;
    logic [3:0] c;
    wait_n(3);
    rst = 1'b0;
    // R1: control reset value and outputs
    check("R1 outs", {3'b0, loop_o, out2_o, out1_o, rts_o, dtr_o}, 8'h08);
    msi_en = 1'b1;
    wait_n(6);
    check("R1 msi", {7'b0, msi_o}, 8'h00);
    reg_rd(1'b0, rv);
    check("R1 ctrl", rv, 8'h08);
    // R3: power-up levels with no change flags
    reg_rd(1'b1, rv);
    check("R3 status", rv, 8'hD0);

    // R2 / R9: every control value, upper write bits ignored
    for (int v = 0; v < 32; v++) begin
      reg_wr(1'b0, {3'b101, v[4:0]});
      check("R2 outs", {3'b0, loop_o, out2_o, out1_o, rts_o, dtr_o}, {3'b0, v[4:0]});
      check("R9 loop", {7'b0, loop_o}, {7'b0, v[4]});
      reg_rd(1'b0, rv);
      check("R2 read", rv, {3'b0, v[4:0]});
    end
    reg_wr(1'b0, 8'h08);

    // R3 R4 R5 R6 R7: every old/new line pair
    for (int o = 0; o < 16; o++) begin
      for (int n = 0; n < 16; n++) begin
        msi_en = o[0] ^ n[2] ^ 1'b1;
        ln = o[3:0];
        wait_n(5);
        reg_rd(1'b1, rv);
        check("R6 clear msi", {7'b0, msi_o}, 8'h00);
        ln = n[3:0];
        exp_d = {o[3] ^ n[3], o[2] & ~n[2], o[1] ^ n[1], o[0] ^ n[0]};
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R7 early", {7'b0, msi_o}, 8'h00);
        @(negedge clk);
        check("R7 msi", {7'b0, msi_o}, {7'b0, msi_en & (exp_d != 4'b0)});
        reg_rd(1'b1, rv);
        check("R4 R5 status", rv, {n[3:0], exp_d});
        reg_rd(1'b1, rv);
        check("R6 cleared", rv, {n[3:0], 4'b0000});
      end
    end

    // R4: toggle-and-return still flagged, flags accumulate
    ln = 4'b0000; wait_n(5); reg_rd(1'b1, rv);
    ln = 4'b0001; wait_n(2); ln = 4'b0000; wait_n(4);
    ln = 4'b0010; wait_n(5);
    reg_rd(1'b1, rv);
    check("R4 sticky", rv, 8'h23);

    // R10: write to status location has no effect
    reg_wr(1'b1, 8'hFF);
    reg_rd(1'b1, rv);
    check("R10 status", rv, 8'h20);
    reg_rd(1'b0, rv);
    check("R10 ctrl", rv, 8'h08);

    // R8: loopback mapping, pending flag kept through loopback reads
    ln = 4'b0000; wait_n(5);
    for (int k = 0; k < 16; k++) begin
      c = k[3:0];
      reg_wr(1'b0, {4'b0001, c});
      reg_rd(1'b1, rv);
      check("R8 loop map", rv, {c[3], c[2], c[0], c[1], 4'b0000});
    end
    reg_wr(1'b0, 8'h08);
    reg_rd(1'b1, rv);
    check("R8 flag kept", rv, 8'h02);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule